// File: doc/BRIEF.md
# Programmable DRAM Refresh Address Sequencer

This block generates the address and function code for periodic DRAM refresh reads. Software programs a refresh window through a small register port. The window is a 24-bit base address with a 3-bit function code, a step in bytes (normally one DRAM row), and the number of refresh cycles before the walk restarts. An external periodic timer sends one-cycle request pulses. For each accepted pulse the block raises a byte-read bus request at the current working pointer. It holds that request until the bus acknowledges it, then advances the pointer by the step and counts down the cycles still left.

When the remaining-cycle counter is zero at the moment a request is accepted, the block first reloads the pointer, function code, step and counter from the programmed registers, then issues the access. Software clears the counter before it enables refresh, so the first access starts at the base. After the programmed number of accesses the walk returns to the base. Software can read back the working pointer and the remaining count at any time. A request that arrives while an access is still waiting for its acknowledge is dropped and sets a sticky overrun flag.

Top module: `dram_refresh_walker`

## Requirements
- R1: After synchronous reset, bus_req and overrun are low and every register reads zero, including enable (control bit 0).
- R2: Register map, selected by the 3-bit index. 0: base high word, with bits [10:8] as the function code and bits [7:0] as address bits [23:16]; the other bits read 0. 1: base address bits [15:0]. 2: step. 3: cycle count. 4: working high word, read-only, in the same layout as index 0. 5: working pointer bits [15:0], read-only. 6: remaining count, read/write. 7: control, where bit 0 is enable and read bit 1 is overrun. Writable registers read back what was written.
- R3: A request pulse that is sampled while enable is set and no access is pending raises bus_req from the next cycle. bus_byte is high with it. bus_addr and bus_fc stay constant until bus_ack is sampled.
- R4: If the remaining count is zero when a request is accepted, the access uses the programmed base address and function code, and the remaining count is loaded from the cycle count.
- R5: When bus_ack is sampled during a pending access, bus_req drops in the next cycle. The pointer advances by the active step modulo 2^24, and the remaining count falls by one but never goes below zero.
- R6: With base 0x000100, step 2, count 0x200 and remaining count 0, the addresses run 0x000100, 0x000102, … for 512 accesses, and the 513th access is at 0x000100 again.
- R7: bus_fc equals bits [10:8] of the base high word in force at the last reload. A high word of zero gives function code 000.
- R8: While enable is clear, request pulses are ignored. No bus_req appears, overrun does not change, and the pointer and count are left as they were.
- R9: A request pulse sampled while an access is pending is dropped. The pending address is not changed, and overrun becomes 1 and stays 1 until control is written with bit 1 set.
- R10: Writes to the base, step and count registers do not change the working pointer, function code, step or count until the next reload.
- R11: With a cycle count of zero, every accepted request reloads, so every access is at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_idx (combinational) |
| refresh_pulse | input | 1 | One-cycle refresh request from the timer |
| bus_req | output | 1 | Refresh access pending |
| bus_byte | output | 1 | Access is a byte read (high with bus_req) |
| bus_addr | output | 24 | Refresh read address |
| bus_fc | output | 3 | Refresh function code |
| bus_ack | input | 1 | Bus has completed the pending access |
| overrun | output | 1 | Sticky flag for requests dropped while one was pending |

## Verification
The first pattern is a full sweep of the reference window of 512 accesses and the restart after it. It shows whether the count-down, the reload and the step arithmetic agree over a whole period and not just over the first few accesses. The second window starts near the top of the 24-bit space with a nonzero function code. It shows whether the pointer wraps modulo 2^24 and whether the function code is carried through unchanged. The configuration is rewritten in the middle of a walk to show that changes wait for the next reload. A count of zero shows the degenerate case where every access reloads. Request pulses sent while disabled or while an access is pending show the difference between an ignored request and an overrun.

// File: rtl/rfw_pkg.sv
package rfw_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 24;
    localparam int FC_W   = 3;
    localparam int HI_W   = ADDR_W - WORD_W;
    localparam int NCFG   = 4;

    typedef enum logic [2:0] {
        IDX_BASE_HI = 3'd0,
        IDX_BASE_LO = 3'd1,
        IDX_STEP    = 3'd2,
        IDX_COUNT   = 3'd3,
        IDX_PTR_HI  = 3'd4,
        IDX_PTR_LO  = 3'd5,
        IDX_REMAIN  = 3'd6,
        IDX_CTRL    = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [FC_W-1:0]   fc;
        logic [ADDR_W-1:0] addr;
    } refresh_ptr_t;

    typedef struct packed {
        refresh_ptr_t      base;
        logic [WORD_W-1:0] step;
        logic [WORD_W-1:0] count;
    } window_cfg_t;

    function automatic logic [WORD_W-1:0] pack_hi(input refresh_ptr_t p);
        logic [WORD_W-1:0] w;
        w = '0;
        w[HI_W+FC_W-1:HI_W] = p.fc;
        w[HI_W-1:0]         = p.addr[ADDR_W-1:WORD_W];
        return w;
    endfunction

    function automatic refresh_ptr_t unpack_ptr(input logic [WORD_W-1:0] hi,
                                                input logic [WORD_W-1:0] lo);
        refresh_ptr_t p;
        p.fc   = hi[HI_W+FC_W-1:HI_W];
        p.addr = {hi[HI_W-1:0], lo};
        return p;
    endfunction

endpackage

// File: rtl/rfw_cfg_regs.sv
module rfw_cfg_regs
    import rfw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    output window_cfg_t       cfg,
    output logic [WORD_W-1:0] base_hi_word,
    output logic [WORD_W-1:0] cfg_word_rd,
    output logic              enable,
    output logic              remain_we,
    output logic              ovr_clr
);
    localparam int HI_KEEP = HI_W + FC_W;

    logic [WORD_W-1:0] word_q [NCFG];

    for (genvar g = 0; g < NCFG; g++) begin : g_word
        localparam int KEEP = (g == 0) ? HI_KEEP : WORD_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[g] <= '0;
            end else if (we && idx == 3'(g)) begin
                word_q[g] <= wdata & WORD_W'((1 << KEEP) - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
        end else if (we && idx == IDX_CTRL) begin
            enable <= wdata[0];
        end
    end

    assign cfg.base     = unpack_ptr(word_q[0], word_q[1]);
    assign cfg.step     = word_q[2];
    assign cfg.count    = word_q[3];
    assign base_hi_word = word_q[0];
    assign cfg_word_rd  = word_q[idx[1:0]];
    assign remain_we    = we && idx == IDX_REMAIN;
    assign ovr_clr      = we && idx == IDX_CTRL && wdata[1];

    // R2: the unused high-word bits can never become set
    a_r2_hi_unused_zero: assert property (@(posedge clk) disable iff (rst)
        base_hi_word[WORD_W-1:HI_KEEP] == '0);

endmodule

// File: rtl/rfw_walker.sv
module rfw_walker
    import rfw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              req,
    input  logic              ack,
    input  window_cfg_t       cfg,
    input  logic              remain_we,
    input  logic [WORD_W-1:0] remain_wdata,
    input  logic              ovr_clr,
    output refresh_ptr_t      ptr,
    output logic [WORD_W-1:0] remain,
    output logic              pending,
    output logic              overrun
);
    logic [WORD_W-1:0] step_act;
    logic              accept;
    logic              reload;

    assign accept = req && enable && !pending;
    assign reload = accept && remain == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            remain   <= '0;
            step_act <= '0;
            pending  <= 1'b0;
        end else begin
            if (reload) begin
                ptr      <= cfg.base;
                step_act <= cfg.step;
            end else if (pending && ack) begin
                ptr.addr <= ptr.addr + ADDR_W'(step_act);
            end

            if (remain_we) begin
                remain <= remain_wdata;
            end else if (reload) begin
                remain <= cfg.count;
            end else if (pending && ack && remain != '0) begin
                remain <= remain - 1'b1;
            end

            if (accept) begin
                pending <= 1'b1;
            end else if (pending && ack) begin
                pending <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end else if (req && enable && pending) begin
            overrun <= 1'b1;
        end
    end

    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        pending && !ack |=> pending && $stable(ptr));

    a_r5_release_on_ack: assert property (@(posedge clk) disable iff (rst)
        pending && ack |=> !pending);

    a_r5_remain_floor: assert property (@(posedge clk) disable iff (rst)
        pending && ack && !remain_we && remain == '0 |=> remain == '0);

    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !pending && !enable |=> !pending && $stable(ptr));

    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        pending && req && enable && !ovr_clr |=> overrun && $stable(ptr));

    a_r11_zero_count_base: assert property (@(posedge clk) disable iff (rst)
        accept && cfg.count == '0 && remain == '0 && !remain_we |=> ptr == $past(cfg.base));

endmodule

// File: rtl/dram_refresh_walker.sv
module dram_refresh_walker
    import rfw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_idx,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        refresh_pulse,
    output logic        bus_req,
    output logic        bus_byte,
    output logic [23:0] bus_addr,
    output logic [2:0]  bus_fc,
    input  logic        bus_ack,
    output logic        overrun
);
    window_cfg_t       cfg;
    logic [WORD_W-1:0] base_hi_word;
    logic [WORD_W-1:0] cfg_word_rd;
    logic              enable;
    logic              remain_we;
    logic              ovr_clr;
    refresh_ptr_t      ptr;
    logic [WORD_W-1:0] remain;
    logic              pending;

    rfw_cfg_regs u_cfg (
        .clk          (clk),
        .rst          (rst),
        .we           (reg_we),
        .idx          (reg_idx),
        .wdata        (reg_wdata),
        .cfg          (cfg),
        .base_hi_word (base_hi_word),
        .cfg_word_rd  (cfg_word_rd),
        .enable       (enable),
        .remain_we    (remain_we),
        .ovr_clr      (ovr_clr)
    );

    rfw_walker u_walk (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .req          (refresh_pulse),
        .ack          (bus_ack),
        .cfg          (cfg),
        .remain_we    (remain_we),
        .remain_wdata (reg_wdata),
        .ovr_clr      (ovr_clr),
        .ptr          (ptr),
        .remain       (remain),
        .pending      (pending),
        .overrun      (overrun)
    );

    always_comb begin
        unique case (reg_idx)
            IDX_PTR_HI: reg_rdata = pack_hi(ptr);
            IDX_PTR_LO: reg_rdata = ptr.addr[WORD_W-1:0];
            IDX_REMAIN: reg_rdata = remain;
            IDX_CTRL:   reg_rdata = {14'd0, overrun, enable};
            default:    reg_rdata = cfg_word_rd;
        endcase
    end

    assign bus_req  = pending;
    assign bus_byte = pending;
    assign bus_addr = ptr.addr;
    assign bus_fc   = ptr.fc;

    a_r3_byte_with_req: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_byte);

    a_r7_fc_stable_pending: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> $stable(bus_fc));

endmodule

// File: tb/dram_refresh_walker_tb.sv
module dram_refresh_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        refresh_pulse = 1'b0;
    logic        bus_req;
    logic        bus_byte;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic        bus_ack = 1'b0;
    logic        overrun;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dram_refresh_walker dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .refresh_pulse(refresh_pulse), .bus_req(bus_req), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_ack(bus_ack), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_idx = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        reg_idx = a;
        #1;
        chk(req, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    task automatic pulse();
        refresh_pulse = 1'b1;
        @(negedge clk);
        refresh_pulse = 1'b0;
    endtask

    task automatic ack();
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
    endtask

    // One refresh access; detail=1 checks every field, else only the address and fc
    task automatic access(input string req, input logic [23:0] ea, input logic [2:0] efc,
                          input bit detail);
        pulse();
        if (detail) begin
            chk({req, " R3 req"}, {31'd0, bus_req}, 32'd1);
            chk({req, " R3 byte"}, {31'd0, bus_byte}, 32'd1);
        end
        chk({req, " addr"}, {8'd0, bus_addr}, {8'd0, ea});
        chk({req, " R7 fc"}, {29'd0, bus_fc}, {29'd0, efc});
        if (detail) begin
            @(negedge clk);
            chk({req, " R3 held"}, {5'd0, bus_fc, bus_addr}, {5'd0, efc, ea});
        end
        ack();
        if (detail) chk({req, " R5 drop"}, {31'd0, bus_req}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [23:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 overrun", {31'd0, overrun}, 32'd0);
        for (int i = 0; i < 8; i++) rd_chk("R1 reg", 3'(i), 16'h0000);

        // R2 register readback with unused high bits masked
        wr(3'd0, 16'hFFFF); rd_chk("R2 base_hi", 3'd0, 16'h07FF);
        wr(3'd1, 16'hA5C3); rd_chk("R2 base_lo", 3'd1, 16'hA5C3);
        wr(3'd2, 16'h1234); rd_chk("R2 step", 3'd2, 16'h1234);
        wr(3'd3, 16'h0F0F); rd_chk("R2 count", 3'd3, 16'h0F0F);
        wr(3'd6, 16'h0042); rd_chk("R2 remain", 3'd6, 16'h0042);
        wr(3'd6, 16'h0000);

        // R6 reference window: R7 high word zero gives fc 000
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0100); wr(3'd2, 16'h0002);
        wr(3'd3, 16'h0200); wr(3'd6, 16'h0000);

        // R8 disabled: the pulse is ignored
        pulse(); @(negedge clk);
        chk("R8 no req", {31'd0, bus_req}, 32'd0);
        chk("R8 no overrun", {31'd0, overrun}, 32'd0);
        rd_chk("R8 remain kept", 3'd6, 16'h0000);
        rd_chk("R8 ptr kept", 3'd5, 16'h0000);

        wr(3'd7, 16'h0001);
        rd_chk("R2 ctrl", 3'd7, 16'h0001);
        access("R4 first", 24'h000100, 3'd0, 1'b1);
        rd_chk("R4 remain load", 3'd6, 16'h01FF);
        rd_chk("R5 ptr step", 3'd5, 16'h0102);
        for (int i = 1; i < 512; i++) begin
            a = 24'h000100 + 24'(2 * i);
            access("R6 sweep", a, 3'd0, 1'b0);
        end
        rd_chk("R6 remain end", 3'd6, 16'h0000);
        access("R6 wrap", 24'h000100, 3'd0, 1'b1);

        // R9 overrun: pulse while pending
        pulse();
        pulse();
        chk("R9 overrun", {31'd0, overrun}, 32'd1);
        chk("R9 addr kept", {8'd0, bus_addr}, 32'h000102);
        ack();
        @(negedge clk);
        chk("R9 sticky", {31'd0, overrun}, 32'd1);
        rd_chk("R9 ctrl read", 3'd7, 16'h0003);
        wr(3'd7, 16'h0003);
        chk("R9 cleared", {31'd0, overrun}, 32'd0);

        // R5 24-bit wrap, R7 nonzero fc, count 3
        wr(3'd7, 16'h0000); wr(3'd6, 16'h0000);
        wr(3'd0, 16'h05FF); wr(3'd1, 16'hFFF8); wr(3'd2, 16'h0010); wr(3'd3, 16'h0003);
        wr(3'd7, 16'h0001);
        access("R7 fc5", 24'hFFFFF8, 3'd5, 1'b1);
        rd_chk("R7 ptr_hi", 3'd4, 16'h0500);
        access("R5 wrap24", 24'h000008, 3'd5, 1'b1);
        // R10 config change mid-walk waits for reload
        wr(3'd0, 16'h0201); wr(3'd1, 16'h2000); wr(3'd2, 16'h0004); wr(3'd3, 16'h0002);
        access("R10 old step", 24'h000018, 3'd5, 1'b0);
        access("R10 reload", 24'h012000, 3'd2, 1'b1);
        access("R10 new step", 24'h012004, 3'd2, 1'b0);
        access("R10 wrap", 24'h012000, 3'd2, 1'b0);

        // R11 count zero: always base
        wr(3'd3, 16'h0000); wr(3'd6, 16'h0000);
        for (int i = 0; i < 4; i++) access("R11 base", 24'h012000, 3'd2, 1'b0);
        rd_chk("R11 remain", 3'd6, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule